// File: doc/BRIEF.md
# Synchronous Bus Clock Prescaler

This block derives four related clock domains (processor core, high-speed system bus, and two peripheral buses called A and B) from one main clock. Every clock is modelled as an enable strobe on a single fast system clock. The main clock is taken either from an oscillator strobe or from a PLL strobe. Each domain gets a pulse train whose rate is the main rate divided by a power of two. Each domain also has a mask register that turns its pulse into a per-module clock enable, one bit per module.

Software reaches the block through a small register port with a write strobe, an address and write data, and a registered read path. One control word holds the main-source select and one divide field per domain. The block refuses any control word that would make a child domain faster than its parent. Peripheral buses A and B are children of the high-speed bus, which is a child of the processor domain. A refused write sets a sticky error flag. An accepted divide setting is held back until the next edge on which every domain pulses together, so no domain ever emits a short period.

Top module: `bclk_prescaler`

## Requirements
- R1: After reset the control word reads 0, every mask reads all ones, and the status error bit reads 0, so all four domains pulse on every main tick.
- R2: Control bit 16 selects the main tick source: 1 takes `pll_tick`, 0 takes `osc_tick`. The strobe that is not selected has no effect on any domain.
- R3: The control word holds one 4-bit field per domain at bits [4d+3:4d], with d = 0 for the processor, 1 for the high-speed bus, 2 for peripheral bus A and 3 for peripheral bus B. Bit 3 of a field is the divide enable and bits 2:0 are the select. With the enable clear the domain pulses on every main tick. With the enable set it pulses once every 2^(select+1) main ticks.
- R4: A control write whose divide settings make the high-speed bus faster than the processor, or either peripheral bus faster than the high-speed bus, is refused. The control word and the active rates stay unchanged, and status bit 0 is set.
- R5: Status bit 0 (address 5) stays set through later accepted writes. Only a write to address 5 with data bit 0 = 1 clears it.
- R6: Addresses 1 to 4 hold the masks of the processor, the high-speed bus, peripheral bus A and peripheral bus B, in that order. Module enable bit n of a domain is high exactly in the cycles where that domain pulses and mask bit n is 1.
- R7: An accepted divide setting takes effect only at the common edge, where the main tick arrives with the phase counter at its last value. All four domains pulse at that edge, and until then the old rates continue.
- R8: A control write accepted in the very cycle of a common edge takes effect at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | Oscillator-derived main clock strobe |
| pll_tick | input | 1 | PLL-derived main clock strobe |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address (0 control, 1-4 masks, 5 status) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for cfg_addr |
| dom_tick | output | 4 | Domain pulses: bit 0 processor, 1 high-speed bus, 2 bus A, 3 bus B |
| cpu_mod_en | output | 32 | Per-module enables, processor domain |
| hsb_mod_en | output | 32 | Per-module enables, high-speed bus domain |
| pba_mod_en | output | 32 | Per-module enables, peripheral bus A |
| pbb_mod_en | output | 32 | Per-module enables, peripheral bus B |

## Verification
The write path and the rate update can land in one cycle: a control write arriving exactly at the common edge, where the held settings are being loaded into the dividers. The bench first sets every domain to the slowest ratio, so that the peripheral bus B pulse marks each common edge. It then times an all-undivided control write to be sampled exactly 256 cycles later. The outcome is judged by all four domains pulsing at that edge and the processor domain pulsing again in the very next cycle. A write placed mid-period is checked to leave the old rates running until the edge.

// File: rtl/bclk_pkg.sv
package bclk_pkg;
  localparam int NDOM   = 4;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    DOM_CPU = 2'd0,
    DOM_HSB = 2'd1,
    DOM_PBA = 2'd2,
    DOM_PBB = 2'd3
  } dom_e;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK0 = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd5;
endpackage

// File: rtl/bclk_cfg_regs.sv
module bclk_cfg_regs
  import bclk_pkg::*;
#(
  parameter int SEL_W  = 3,
  parameter int NMOD   = 32,
  parameter int DATA_W = 32,
  localparam int FLD_W = SEL_W + 1,
  localparam int SHW   = $clog2((1 << SEL_W) + 1),
  localparam int CTL_W = NDOM * FLD_W + 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cfg_wr,
  input  logic [ADDR_W-1:0]              cfg_addr,
  input  logic [DATA_W-1:0]              cfg_wdata,
  output logic [DATA_W-1:0]              cfg_rdata,
  output logic                           pll_sel,
  output logic [NDOM-1:0][SHW-1:0]       shift_next,
  output logic [NDOM-1:0][NMOD-1:0]      mask
);
  logic [CTL_W-1:0]           ctrl_q;
  logic [NDOM-1:0][NMOD-1:0]  mask_q;
  logic                       err_q;
  logic [DATA_W-1:0]          rdata_q;
  logic [NDOM-1:0][SHW-1:0]   cand, cur;
  logic                       cand_ok, wr_ctrl, accept;
  logic [DATA_W-1:0]          rd_mux;

  function automatic logic [SHW-1:0] fld_shift(input logic [FLD_W-1:0] f);
    return f[FLD_W-1] ? SHW'(f[SEL_W-1:0]) + SHW'(1) : '0;
  endfunction

  always_comb begin
    for (int d = 0; d < NDOM; d++) begin
      cand[d] = fld_shift(cfg_wdata[d*FLD_W +: FLD_W]);
      cur[d]  = fld_shift(ctrl_q[d*FLD_W +: FLD_W]);
    end
    cand_ok = (cand[DOM_CPU] <= cand[DOM_HSB]) &&
              (cand[DOM_HSB] <= cand[DOM_PBA]) &&
              (cand[DOM_HSB] <= cand[DOM_PBB]);
    wr_ctrl    = cfg_wr && (cfg_addr == A_CTRL);
    accept     = wr_ctrl && cand_ok;
    shift_next = accept ? cand : cur;
  end

  always_comb begin
    rd_mux = '0;
    if (cfg_addr == A_CTRL) rd_mux = DATA_W'(ctrl_q);
    if (cfg_addr == A_STAT) rd_mux = DATA_W'(err_q);
    for (int d = 0; d < NDOM; d++)
      if (cfg_addr == A_MASK0 + ADDR_W'(d)) rd_mux = DATA_W'(mask_q[d]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      mask_q  <= '1;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      rdata_q <= rd_mux;
      if (accept) ctrl_q <= cfg_wdata[CTL_W-1:0];
      if (wr_ctrl && !cand_ok) err_q <= 1'b1;
      else if (cfg_wr && cfg_addr == A_STAT && cfg_wdata[0]) err_q <= 1'b0;
      for (int d = 0; d < NDOM; d++)
        if (cfg_wr && cfg_addr == A_MASK0 + ADDR_W'(d))
          mask_q[d] <= cfg_wdata[NMOD-1:0];
    end
  end

  assign cfg_rdata = rdata_q;
  assign pll_sel   = ctrl_q[CTL_W-1];
  assign mask      = mask_q;

  // R4
  reject_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && !cand_ok) |=> ($stable(ctrl_q) && err_q));

  // R5
  sticky_err_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(err_q) |-> $past(cfg_wr && cfg_addr == A_STAT && cfg_wdata[0]));
endmodule

// File: rtl/bclk_divider.sv
module bclk_divider
  import bclk_pkg::*;
#(
  parameter int SEL_W = 3,
  localparam int SHW   = $clog2((1 << SEL_W) + 1),
  localparam int CNT_W = 1 << SEL_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     main_tick,
  input  logic [NDOM-1:0][SHW-1:0] shift_next,
  output logic [NDOM-1:0]          tick_d,
  output logic [NDOM-1:0]          dom_tick
);
  logic [CNT_W-1:0]          cnt_q;
  logic [NDOM-1:0][SHW-1:0]  act_q;
  logic [NDOM-1:0]           tick_q;
  logic                      common;

  always_comb begin
    logic [CNT_W-1:0] lowm;
    for (int d = 0; d < NDOM; d++) begin
      lowm      = ~({CNT_W{1'b1}} << act_q[d]);
      tick_d[d] = main_tick && ((cnt_q & lowm) == lowm);
    end
    common = main_tick && (&cnt_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      act_q  <= '0;
      tick_q <= '0;
    end else begin
      if (main_tick) cnt_q <= cnt_q + CNT_W'(1);
      if (common) act_q <= shift_next;
      tick_q <= tick_d;
    end
  end

  assign dom_tick = tick_q;

  // R7
  common_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_q) |-> (&tick_q));

  // R4
  order_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (act_q[DOM_CPU] <= act_q[DOM_HSB]) && (act_q[DOM_HSB] <= act_q[DOM_PBA]) &&
    (act_q[DOM_HSB] <= act_q[DOM_PBB]));
endmodule

// File: rtl/bclk_gate.sv
module bclk_gate
  import bclk_pkg::*;
#(
  parameter int NMOD = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NDOM-1:0]           tick_d,
  input  logic [NDOM-1:0]           dom_tick,
  input  logic [NDOM-1:0][NMOD-1:0] mask,
  output logic [NDOM-1:0][NMOD-1:0] mod_en
);
  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    logic [NMOD-1:0] en_q;
    always_ff @(posedge clk) begin
      if (rst) en_q <= '0;
      else     en_q <= tick_d[d] ? mask[d] : '0;
    end
    assign mod_en[d] = en_q;

    // R6
    gated_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      (en_q != '0) |-> dom_tick[d]);
  end
endmodule

// File: rtl/bclk_prescaler.sv
module bclk_prescaler
  import bclk_pkg::*;
#(
  parameter int SEL_W  = 3,
  parameter int NMOD   = 32,
  parameter int DATA_W = 32,
  localparam int SHW   = $clog2((1 << SEL_W) + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              osc_tick,
  input  logic              pll_tick,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic [NDOM-1:0]   dom_tick,
  output logic [NMOD-1:0]   cpu_mod_en,
  output logic [NMOD-1:0]   hsb_mod_en,
  output logic [NMOD-1:0]   pba_mod_en,
  output logic [NMOD-1:0]   pbb_mod_en
);
  logic                      pll_sel, main_tick;
  logic [NDOM-1:0][SHW-1:0]  shift_next;
  logic [NDOM-1:0][NMOD-1:0] mask, mod_en;
  logic [NDOM-1:0]           tick_d;

  assign main_tick = pll_sel ? pll_tick : osc_tick;

  bclk_cfg_regs #(.SEL_W(SEL_W), .NMOD(NMOD), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pll_sel(pll_sel),
    .shift_next(shift_next), .mask(mask)
  );

  bclk_divider #(.SEL_W(SEL_W)) u_div (
    .clk(clk), .rst(rst), .main_tick(main_tick), .shift_next(shift_next),
    .tick_d(tick_d), .dom_tick(dom_tick)
  );

  bclk_gate #(.NMOD(NMOD)) u_gate (
    .clk(clk), .rst(rst), .tick_d(tick_d), .dom_tick(dom_tick),
    .mask(mask), .mod_en(mod_en)
  );

  assign cpu_mod_en = mod_en[DOM_CPU];
  assign hsb_mod_en = mod_en[DOM_HSB];
  assign pba_mod_en = mod_en[DOM_PBA];
  assign pbb_mod_en = mod_en[DOM_PBB];
endmodule

// File: tb/bclk_prescaler_test.sv
module bclk_prescaler_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        osc_tick = 1'b0, pll_tick = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [3:0]  dom_tick;
  logic [31:0] cpu_mod_en, hsb_mod_en, pba_mod_en, pbb_mod_en;

  int checks = 0, failures = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  bclk_prescaler uut (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .pll_tick(pll_tick),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .dom_tick(dom_tick), .cpu_mod_en(cpu_mod_en),
    .hsb_mod_en(hsb_mod_en), .pba_mod_en(pba_mod_en), .pbb_mod_en(pbb_mod_en)
  );

  // {refused, control word}
  localparam logic [17:0] VEC [7] = '{
    {1'b0, 17'h00000}, {1'b0, 17'h0FA80}, {1'b0, 17'h0C999},
    {1'b1, 17'h0008A}, {1'b1, 17'h000B0}, {1'b1, 17'h00BB0},
    {1'b0, 17'h0FFFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    v = cfg_rdata;
  endtask

  task automatic count(input int n, output int c [4]);
    for (int k = 0; k < 4; k++) c[k] = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      for (int k = 0; k < 4; k++) c[k] += int'(dom_tick[k]);
    end
  endtask

  function automatic int exp_cnt(input logic [16:0] c, input int d);
    logic [3:0] f = c[d*4 +: 4];
    int s = f[3] ? int'(f[2:0]) + 1 : 0;
    return 256 >> s;
  endfunction

  task automatic wait_pbb();
    do @(negedge clk); while (!dom_tick[3]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [16:0] cur;
    int c [4];
    int bad;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    osc_tick = 1'b1;

    // R1 reset state
    rd(3'd0, v); chk("R1 ctrl", v, 32'h0);
    rd(3'd4, v); chk("R1 mask", v, 32'hFFFF_FFFF);
    rd(3'd5, v); chk("R1 status", v, 32'h0);
    count(20, c);
    for (int k = 0; k < 4; k++) chk("R1 rate", c[k], 20);
    chk("R1 mod_en", cpu_mod_en, 32'hFFFF_FFFF);

    // R3 / R4 table walk
    cur = '0;
    for (int i = 0; i < 7; i++) begin
      wr(3'd0, 32'(VEC[i][16:0]));
      if (!VEC[i][17]) cur = VEC[i][16:0];
      repeat (300) @(negedge clk);
      rd(3'd0, v); chk(VEC[i][17] ? "R4 ctrl kept" : "R3 ctrl", v, 32'(cur));
      rd(3'd5, v); chk(VEC[i][17] ? "R4 err set" : "R3 err clear", v, 32'(VEC[i][17]));
      count(256, c);
      for (int k = 0; k < 4; k++)
        chk(VEC[i][17] ? "R4 rate kept" : "R3 rate", c[k], exp_cnt(cur, k));
      if (VEC[i][17]) wr(3'd5, 32'h1);
    end

    // R7: mid-period write waits for the common edge
    wait_pbb();
    repeat (99) @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 3'd0; cfg_wdata = 32'h0;
    @(negedge clk);
    cfg_wr = 1'b0;
    bad = 0;
    for (int i = 0; i < 156; i++) begin
      bad += int'(dom_tick[0]);
      if (i < 155) @(negedge clk);
    end
    chk("R7 old rate held", bad, 0);
    @(negedge clk); chk("R7 common edge", dom_tick, 4'hF);
    @(negedge clk); chk("R7 new rate", dom_tick[0], 1'b1);

    // R8: write lands on the common edge itself
    wr(3'd0, 32'h0FFFF);
    repeat (300) @(negedge clk);
    wait_pbb();
    repeat (255) @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 3'd0; cfg_wdata = 32'h0;
    @(negedge clk);
    cfg_wr = 1'b0;
    chk("R8 common edge", dom_tick, 4'hF);
    @(negedge clk);
    chk("R8 applied same edge", {dom_tick[3], dom_tick[0]}, 2'b11);

    // R6 masks
    wr(3'd1, 32'h0);
    wr(3'd3, 32'h0000_00A5);
    repeat (3) @(negedge clk);
    chk("R6 cpu masked", cpu_mod_en, 32'h0);
    chk("R6 pba partial", pba_mod_en, 32'h0000_00A5);
    chk("R6 hsb full", hsb_mod_en, 32'hFFFF_FFFF);
    rd(3'd3, v); chk("R6 mask read", v, 32'h0000_00A5);
    wr(3'd0, 32'h0F000);
    repeat (300) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (pbb_mod_en !== (dom_tick[3] ? 32'hFFFF_FFFF : 32'h0)) bad++;
    end
    chk("R6 pbb gated by pulse", bad, 0);

    // R5 sticky error
    wr(3'd0, 32'h0008A);
    rd(3'd5, v); chk("R5 err set", v, 32'h1);
    wr(3'd0, 32'h0);
    rd(3'd5, v); chk("R5 err sticky", v, 32'h1);
    rd(3'd0, v); chk("R5 good write taken", v, 32'h0);
    wr(3'd5, 32'h0);
    rd(3'd5, v); chk("R5 zero write no clear", v, 32'h1);
    wr(3'd5, 32'h1);
    rd(3'd5, v); chk("R5 err cleared", v, 32'h0);

    // R2 source select
    repeat (300) @(negedge clk);
    wr(3'd0, 32'h10000);
    osc_tick = 1'b1; pll_tick = 1'b0;
    repeat (5) @(negedge clk);
    count(50, c); chk("R2 osc ignored", c[0], 0);
    pll_tick = 1'b1;
    repeat (5) @(negedge clk);
    count(50, c); chk("R2 pll used", c[0], 50);
    wr(3'd0, 32'h0);
    osc_tick = 1'b0;
    repeat (5) @(negedge clk);
    count(50, c); chk("R2 pll ignored", c[0], 0);

    finish_run();
  end
endmodule